// File: doc/BRIEF.md
# Quiz Round Buzzer Controller

This block runs a single round of a four-contestant quiz. Each round begins when the host presses start. That press opens a timed buzz-in window, and the first contestant to press a button during the window wins the right to answer. A winning press starts an answer countdown. The block raises a flag for each of three conditions: a contestant pressed while the round was idle, nobody pressed before the window closed, or the answer time is in its last few seconds. A remaining-seconds count is also presented for an external display. Button debouncing, scoring and segment decoding belong to other blocks.

All inputs are asynchronous to the block. Each one passes through a two-flop synchronizer, and only its rising edge counts, so a button held down counts as one press. A clock-enable divider derives a one-second tick from the system clock. The divide ratio is a parameter, so simulation can use a short "second". Each alarm and each latched vector keeps its value until the next accepted start or a reset.

Top module: `quiz_buzzer`

## Requirements
- R1: A synchronous active-high `rst` clears every output to zero and puts the block in the idle phase.
- R2: A start rising edge seen while idle opens the buzz-in window. It loads `secs_o` with WINDOW_SEC, clears `early_o`, `winner_o` and all three alarms, and takes effect on the third clock edge after the input changes.
- R3: A button rising edge seen while idle sets that button's bit in `early_o` (bit i is button i) and raises `alarm_early_o`. Both stay set until the next accepted start.
- R4: During the window, the first button rising edge is latched into `winner_o` as a one-hot vector (bit i is button i). When several buttons are first seen in the same cycle, the lowest index wins.
- R5: Once a winner is latched, further button presses and start pulses have no effect until the round returns to idle.
- R6: If no press arrives within WINDOW_SEC ticks, `alarm_timeout_o` rises, `secs_o` becomes 0 and the block returns to idle.
- R7: A winning press loads `secs_o` with ANSWER_SEC. The count then decrements once every TICK_DIV clock cycles, with the first decrement TICK_DIV cycles after the load.
- R8: `alarm_warn_o` rises on the decrement that brings `secs_o` to WARN_SEC or below during the answer phase, and it stays set.
- R9: When the answer count reaches 0, the block returns to idle with `winner_o` still shown, and a new start begins the next round.
- R10: A button that is already held when start arrives does not win. Only a new rising edge inside the window counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Host start button, asynchronous |
| btn_i | input | N_PLAYERS | Contestant buttons, asynchronous, bit i is contestant i |
| early_o | output | N_PLAYERS | One-hot-per-press record of presses made while idle |
| winner_o | output | N_PLAYERS | One-hot latched winner of the round |
| alarm_early_o | output | 1 | A press was made before start |
| alarm_timeout_o | output | 1 | Window closed with no press |
| alarm_warn_o | output | 1 | Answer time is in its last WARN_SEC seconds |
| secs_o | output | SEC_W | Remaining seconds of the current phase |

## Verification
The assertions assume that `rst` is held for at least one clock, and that the only changes to the outputs come from the internal phase sequence driven by synchronized edges. They also assume the inputs are clean levels, with no glitching narrower than a clock, because debouncing happens upstream. The stimulus changes every input only on the falling clock edge and holds each press for at least one full cycle. It never asserts reset together with a pending edge it expects to count. All expected outputs are sampled at falling edges, after counting the two synchronizer stages and the phase register.

// File: rtl/qb_pkg.sv
package qb_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_WINDOW = 2'd1,
    PH_ANSWER = 2'd2
  } phase_e;
endpackage

// File: rtl/qb_sync_edge.sv
module qb_sync_edge #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] rise_o
);
  generate
    for (genvar g = 0; g < W; g++) begin : g_bit
      logic meta_q, sync_q, last_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          meta_q <= 1'b0;
          sync_q <= 1'b0;
          last_q <= 1'b0;
        end else begin
          meta_q <= raw_i[g];
          sync_q <= meta_q;
          last_q <= sync_q;
        end
      end
      assign rise_o[g] = sync_q & ~last_q;
    end
  endgenerate
endmodule

// File: rtl/qb_tick.sv
module qb_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST) & ~clr_i;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/qb_arbiter.sv
module qb_arbiter #(
  parameter int N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;
  generate
    for (genvar g = 0; g < N; g++) begin : g_pri
      assign grant_o[g]  = req_i[g] & ~seen[g];
      assign seen[g + 1] = seen[g] | req_i[g];
    end
  endgenerate
endmodule

// File: rtl/qb_ctrl.sv
module qb_ctrl
  import qb_pkg::*;
#(
  parameter int N          = 4,
  parameter int SEC_W      = 6,
  parameter int WINDOW_SEC = 20,
  parameter int ANSWER_SEC = 60,
  parameter int WARN_SEC   = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_rise_i,
  input  logic [N-1:0]     press_i,
  input  logic [N-1:0]     grant_i,
  input  logic             tick_i,
  output logic             div_clr_o,
  output phase_e           phase_o,
  output logic [N-1:0]     early_o,
  output logic [N-1:0]     winner_o,
  output logic             alarm_early_o,
  output logic             alarm_timeout_o,
  output logic             alarm_warn_o,
  output logic [SEC_W-1:0] secs_o
);
  localparam logic [SEC_W-1:0] WIN_LOAD = SEC_W'(WINDOW_SEC);
  localparam logic [SEC_W-1:0] ANS_LOAD = SEC_W'(ANSWER_SEC);
  localparam logic [SEC_W-1:0] WARN_LIM = SEC_W'(WARN_SEC);
  localparam logic [SEC_W-1:0] ONE      = SEC_W'(1);

  phase_e           phase_q;
  logic [SEC_W-1:0] secs_q;
  logic [SEC_W-1:0] secs_dec;
  logic [N-1:0]     early_q, winner_q;
  logic             a_early_q, a_time_q, a_warn_q;
  logic             go, won;

  assign secs_dec  = secs_q - ONE;
  assign go        = (phase_q == PH_IDLE) && start_rise_i;
  assign won       = (phase_q == PH_WINDOW) && (|grant_i);
  assign div_clr_o = go || won;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_IDLE;
      secs_q    <= '0;
      early_q   <= '0;
      winner_q  <= '0;
      a_early_q <= 1'b0;
      a_time_q  <= 1'b0;
      a_warn_q  <= 1'b0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (start_rise_i) begin
            phase_q   <= PH_WINDOW;
            secs_q    <= WIN_LOAD;
            early_q   <= '0;
            winner_q  <= '0;
            a_early_q <= 1'b0;
            a_time_q  <= 1'b0;
            a_warn_q  <= 1'b0;
          end else if (|press_i) begin
            early_q   <= early_q | press_i;
            a_early_q <= 1'b1;
          end
        end
        PH_WINDOW: begin
          if (|grant_i) begin
            phase_q  <= PH_ANSWER;
            winner_q <= grant_i;
            secs_q   <= ANS_LOAD;
            if (ANS_LOAD <= WARN_LIM) a_warn_q <= 1'b1;
          end else if (tick_i) begin
            if (secs_q <= ONE) begin
              phase_q  <= PH_IDLE;
              secs_q   <= '0;
              a_time_q <= 1'b1;
            end else begin
              secs_q <= secs_dec;
            end
          end
        end
        PH_ANSWER: begin
          if (tick_i) begin
            if (secs_q <= ONE) begin
              phase_q <= PH_IDLE;
              secs_q  <= '0;
            end else begin
              secs_q <= secs_dec;
            end
            if (secs_dec <= WARN_LIM) a_warn_q <= 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o         = phase_q;
  assign secs_o          = secs_q;
  assign early_o         = early_q;
  assign winner_o        = winner_q;
  assign alarm_early_o   = a_early_q;
  assign alarm_timeout_o = a_time_q;
  assign alarm_warn_o    = a_warn_q;
endmodule

// File: rtl/quiz_buzzer.sv
module quiz_buzzer
  import qb_pkg::*;
#(
  parameter int N_PLAYERS  = 4,
  parameter int TICK_DIV   = 200_000_000,
  parameter int WINDOW_SEC = 20,
  parameter int ANSWER_SEC = 60,
  parameter int WARN_SEC   = 5,
  parameter int MAX_SEC    = (WINDOW_SEC > ANSWER_SEC) ? WINDOW_SEC : ANSWER_SEC,
  parameter int SEC_W      = $clog2(MAX_SEC + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic [N_PLAYERS-1:0] btn_i,
  output logic [N_PLAYERS-1:0] early_o,
  output logic [N_PLAYERS-1:0] winner_o,
  output logic                 alarm_early_o,
  output logic                 alarm_timeout_o,
  output logic                 alarm_warn_o,
  output logic [SEC_W-1:0]     secs_o
);
  logic                 start_rise;
  logic [N_PLAYERS-1:0] press;
  logic [N_PLAYERS-1:0] grant;
  logic                 tick;
  logic                 div_clr;
  phase_e               phase;

  qb_sync_edge #(.W(1)) u_start_sync (
    .clk(clk), .rst(rst), .raw_i(start_i), .rise_o(start_rise)
  );

  qb_sync_edge #(.W(N_PLAYERS)) u_btn_sync (
    .clk(clk), .rst(rst), .raw_i(btn_i), .rise_o(press)
  );

  qb_arbiter #(.N(N_PLAYERS)) u_arb (
    .req_i(press), .grant_o(grant)
  );

  qb_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .clr_i(div_clr), .tick_o(tick)
  );

  qb_ctrl #(
    .N(N_PLAYERS), .SEC_W(SEC_W), .WINDOW_SEC(WINDOW_SEC),
    .ANSWER_SEC(ANSWER_SEC), .WARN_SEC(WARN_SEC)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .start_rise_i(start_rise), .press_i(press), .grant_i(grant),
    .tick_i(tick), .div_clr_o(div_clr), .phase_o(phase),
    .early_o(early_o), .winner_o(winner_o),
    .alarm_early_o(alarm_early_o), .alarm_timeout_o(alarm_timeout_o),
    .alarm_warn_o(alarm_warn_o), .secs_o(secs_o)
  );
endmodule

// File: rtl/qb_checker.sv
module qb_checker
  import qb_pkg::*;
#(
  parameter int N       = 4,
  parameter int SEC_W   = 6,
  parameter int MAX_SEC = 60
) (
  input logic             clk,
  input logic             rst,
  input phase_e           phase,
  input logic [N-1:0]     early_o,
  input logic [N-1:0]     winner_o,
  input logic             alarm_early_o,
  input logic             alarm_timeout_o,
  input logic             alarm_warn_o,
  input logic [SEC_W-1:0] secs_o
);
  // R4: a single winner at most
  assert_winner_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(winner_o));

  // R5: a latched winner only changes by being cleared at the next start
  assert_winner_held_R5: assert property (@(posedge clk) disable iff (rst)
    (|winner_o) |=> (winner_o == $past(winner_o)) || (winner_o == '0));

  // R3: presses outside idle leave the early record alone
  assert_early_frozen_R3: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE) |=> $stable(early_o));

  // R3: early alarm tracks the early record
  assert_early_flag_R3: assert property (@(posedge clk) disable iff (rst)
    alarm_early_o == (|early_o));

  // R6: timeout and a winner never coexist
  assert_timeout_excl_R6: assert property (@(posedge clk) disable iff (rst)
    !(alarm_timeout_o && (|winner_o)));

  // R8: warning only in a round that had a winner
  assert_warn_needs_winner_R8: assert property (@(posedge clk) disable iff (rst)
    alarm_warn_o |-> (|winner_o));

  // R7: the count never exceeds the longest phase
  assert_secs_bound_R7: assert property (@(posedge clk) disable iff (rst)
    secs_o <= SEC_W'(MAX_SEC));

  // R9: idle phase shows no remaining time
  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE) |-> (secs_o == '0));
endmodule

bind quiz_buzzer qb_checker #(
  .N(N_PLAYERS), .SEC_W(SEC_W), .MAX_SEC(MAX_SEC)
) i_qb_checker (
  .clk(clk), .rst(rst), .phase(phase),
  .early_o(early_o), .winner_o(winner_o),
  .alarm_early_o(alarm_early_o), .alarm_timeout_o(alarm_timeout_o),
  .alarm_warn_o(alarm_warn_o), .secs_o(secs_o)
);

// File: tb/test_quiz_buzzer.sv
`timescale 1ns/1ps
module test_quiz_buzzer;
  localparam int N   = 4;
  localparam int DIV = 4;
  localparam int WIN = 3;
  localparam int ANS = 6;
  localparam int WRN = 2;
  localparam int SW  = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [N-1:0]  btn_i = '0;
  logic [N-1:0]  early_o, winner_o;
  logic          alarm_early_o, alarm_timeout_o, alarm_warn_o;
  logic [SW-1:0] secs_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  quiz_buzzer #(
    .N_PLAYERS(N), .TICK_DIV(DIV), .WINDOW_SEC(WIN),
    .ANSWER_SEC(ANS), .WARN_SEC(WRN)
  ) i_quiz_buzzer (
    .clk(clk), .rst(rst), .start_i(start_i), .btn_i(btn_i),
    .early_o(early_o), .winner_o(winner_o),
    .alarm_early_o(alarm_early_o), .alarm_timeout_o(alarm_timeout_o),
    .alarm_warn_o(alarm_warn_o), .secs_o(secs_o)
  );

  // fields: [11:8] idle presses, [7:4] window presses, [3:0] expected winner
  localparam logic [11:0] VEC [0:4] = '{
    12'b0000_0001_0001,
    12'b0010_0110_0010,
    12'b1001_1111_0001,
    12'b0000_1100_0100,
    12'b0100_1000_1000
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // pulse start for one cycle, then wait until the third edge has passed
  task automatic do_start();
    start_i = 1'b1; cyc(1); start_i = 1'b0; cyc(2);
  endtask

  task automatic do_press(input logic [N-1:0] m);
    btn_i = m; cyc(1); btn_i = '0; cyc(2);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R1 reset state
    chk(early_o == 0 && winner_o == 0, "R1", int'({early_o, winner_o}), 0);
    chk({alarm_early_o, alarm_timeout_o, alarm_warn_o} == 0 && secs_o == 0,
        "R1", int'({alarm_early_o, alarm_timeout_o, alarm_warn_o, secs_o}), 0);

    // table of rounds
    for (int i = 0; i < 5; i++) begin
      do_press(VEC[i][11:8]);
      chk(early_o == VEC[i][11:8], "R3", int'(early_o), int'(VEC[i][11:8]));
      chk(alarm_early_o == (|VEC[i][11:8]), "R3", int'(alarm_early_o), int'(|VEC[i][11:8]));
      do_start();
      chk(secs_o == SW'(WIN) && early_o == 0 && !alarm_early_o, "R2",
          int'(secs_o), WIN);
      do_press(VEC[i][7:4]);
      chk(winner_o == VEC[i][3:0], "R4", int'(winner_o), int'(VEC[i][3:0]));
      chk(secs_o == SW'(ANS), "R7", int'(secs_o), ANS);
      cyc(ANS * DIV);
      chk(secs_o == 0 && alarm_warn_o, "R9", int'({alarm_warn_o, secs_o}), 8);
      chk(winner_o == VEC[i][3:0], "R9", int'(winner_o), int'(VEC[i][3:0]));
    end

    // R6 timeout
    do_start();
    cyc(WIN * DIV - 1);
    chk(secs_o == 1 && !alarm_timeout_o, "R6", int'({alarm_timeout_o, secs_o}), 1);
    cyc(1);
    chk(secs_o == 0 && alarm_timeout_o && winner_o == 0, "R6",
        int'({alarm_timeout_o, secs_o}), 8);

    // R10 button held across start never wins
    btn_i = 4'b0001; cyc(3);
    do_start();
    cyc(WIN * DIV);
    chk(alarm_timeout_o && winner_o == 0, "R10", int'(winner_o), 0);
    btn_i = '0; cyc(3);

    // R5 later press and start ignored; R7 timing; R8 warning
    do_start();
    do_press(4'b0100);                 // winner latched, load at edge p3
    do_press(4'b0001);                 // edges p4..p6
    chk(winner_o == 4'b0100, "R5", int'(winner_o), 4);
    do_start();                        // edges p7..p9, decrement at p7
    chk(winner_o == 4'b0100 && secs_o == 5, "R5", int'(secs_o), 5);
    cyc(9);                            // after p18
    chk(secs_o == 3 && !alarm_warn_o, "R8", int'({alarm_warn_o, secs_o}), 3);
    cyc(1);                            // after p19
    chk(secs_o == 2 && alarm_warn_o, "R8", int'({alarm_warn_o, secs_o}), 10);
    cyc(8);                            // after p27
    chk(secs_o == 0 && alarm_warn_o, "R9", int'(secs_o), 0);

    // R1 reset in the middle of a round
    do_start();
    do_press(4'b1000);
    rst = 1'b1; cyc(1); rst = 1'b0; cyc(1);
    chk(winner_o == 0 && secs_o == 0 && !alarm_warn_o, "R1",
        int'({winner_o, secs_o}), 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule